// File: doc/BRIEF.md
# Fly-by DMA Peripheral Handshake

This block is the device-side half of a fly-by DMA link. A third-party DMA controller moves data straight between system memory and the device data bus, never buffering it. The device only raises a request, waits for the acknowledge, and then answers read or write strobes. Each strobe moves one 16-bit word between the bus and the selected endpoint buffer. No address ever reaches the device.

Software arms a transfer with a one-cycle pulse. The pulse latches a 4-bit endpoint code and a direction bit. With direction 0 (OUT) the device supplies words on read strobes. With direction 1 (IN) it absorbs words on write strobes. The endpoint codes in use include 4'b1101, 4'b1110 and 4'b1111.

The acknowledge, strobes and end-of-transfer input all come from another clock domain, so each passes through a two-flop synchroniser. A word is counted on the trailing edge of its strobe. The endpoint buffer itself sits outside the block and is reached through pop/push ports and empty/full flags.

Top module: `flyby_dma_port`

## Requirements
- R1: While reset is active and after it releases, `dreq`, `bus_oe`, `buf_pop`, `buf_push`, `xfer_done`, `xfer_err` are 0 and `word_cnt` is 0.
- R2: `dreq` is 1 only when a transfer is armed, `ack_only` is 0, and the latched buffer can still take part: not empty when direction is 0 (OUT), not full when direction is 1 (IN). It drops within two clocks of the buffer becoming empty or full.
- R3: `bus_oe` is 1 only while the synchronised acknowledge and read strobe are both high on an armed OUT transfer. While it is high, `bus_rdata` equals the head word of the buffer.
- R4: Each read strobe with acknowledge on an armed OUT transfer pops exactly one word on its trailing edge. Each word moved, in either direction, adds 1 to `word_cnt`. Pop and push are never active together.
- R5: Each write strobe with acknowledge on an armed IN transfer pushes exactly one word on its trailing edge. The word pushed is the one present on `bus_wdata` during the strobe.
- R6: A strobe seen while the acknowledge is low moves no word and drives no data.
- R7: A strobe on an empty buffer (OUT) or a full buffer (IN) moves nothing. It sets the sticky `xfer_err` flag instead.
- R8: A rising `eot` during an armed transfer ends it. `dreq` falls, `xfer_done` becomes 1, and later strobes move nothing until the next arm.
- R9: While `ack_only` is 1, `dreq` stays 0 and read and write strobes move no words.
- R10: An `arm` pulse clears `xfer_done`, `xfer_err` and `word_cnt`. It also latches `ep_sel` and `dir_in`, so later changes to those inputs do not alter `buf_sel` or the direction mid-transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_only | input | 1 | 1 disables strobe-driven DMA |
| dir_in | input | 1 | Direction to latch at arm: 0 OUT, 1 IN |
| ep_sel | input | 4 | Endpoint code to latch at arm |
| arm | input | 1 | One-cycle pulse starting a transfer |
| dma_ack | input | 1 | Asynchronous acknowledge from DMA controller |
| rd_strb | input | 1 | Asynchronous read strobe |
| wr_strb | input | 1 | Asynchronous write strobe |
| eot | input | 1 | Asynchronous end-of-transfer |
| dreq | output | 1 | Request to DMA controller |
| bus_wdata | input | 16 | Word from the bus on writes |
| bus_rdata | output | 16 | Word to the bus on reads |
| bus_oe | output | 1 | Bus driver enable |
| buf_sel | output | 4 | Latched endpoint code to buffer |
| buf_rdata | input | 16 | Head word of selected buffer |
| buf_empty | input | 1 | Selected buffer empty |
| buf_full | input | 1 | Selected buffer full |
| buf_pop | output | 1 | Consume head word |
| buf_push | output | 1 | Store `buf_wdata` |
| buf_wdata | output | 16 | Word to store |
| xfer_done | output | 1 | Sticky end-of-transfer flag |
| xfer_err | output | 1 | Sticky empty/full strobe error |
| word_cnt | output | 16 | Words moved since arm |

## Verification
The hardest case to reach is a strobe that arrives just after the buffer has drained or filled. It needs an exact word count against a bench buffer model, and a request that must already have dropped. The stimulus fills or drains the modelled buffer to its limit with random data and random strobe widths, then issues one extra strobe. Separate directed passes issue strobes with the acknowledge low, after an end-of-transfer, and with the ack-only bit set. Each pass checks that the count and buffer stay unchanged.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned EP_W   = 4;
  localparam int unsigned CNT_W  = 16;

  typedef enum logic {DIR_OUT = 1'b0, DIR_IN = 1'b1} dir_t;
endpackage

// File: rtl/fbd_sync.sv
module fbd_sync #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] s1_q, s2_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[i] <= 1'b0;
        s2_q[i] <= 1'b0;
      end else begin
        s1_q[i] <= d[i];
        s2_q[i] <= s1_q[i];
      end
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/fbd_edge.sv
module fbd_edge #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/fbd_ctrl.sv
module fbd_ctrl
  import fbd_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter int unsigned EW = EP_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_only,
  input  logic          dir_in,
  input  logic [EW-1:0] ep_sel,
  input  logic          arm,
  input  logic          ack_s,
  input  logic          rd_s,
  input  logic          wr_s,
  input  logic          rd_fall,
  input  logic          wr_fall,
  input  logic          eot_rise,
  input  logic [DW-1:0] bus_wdata,
  input  logic          buf_empty,
  input  logic          buf_full,
  output logic          dreq,
  output logic          bus_oe,
  output logic [EW-1:0] buf_sel,
  output logic          buf_pop,
  output logic          buf_push,
  output logic [DW-1:0] buf_wdata,
  output logic          xfer_done,
  output logic          xfer_err,
  output logic [CW-1:0] word_cnt
);
  logic          active_q, active_n;
  dir_t          dir_q, dir_n;
  logic [EW-1:0] sel_q, sel_n;
  logic          done_q, done_n;
  logic          err_q, err_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          dreq_q, dreq_n;
  logic [DW-1:0] wcap_q;
  logic          wcap_en;
  logic          go, rd_ev, wr_ev, bad;

  always_comb begin
    go       = active_q & ~ack_only;
    rd_ev    = rd_fall & ack_s & go & (dir_q == DIR_OUT);
    wr_ev    = wr_fall & ack_s & go & (dir_q == DIR_IN);
    buf_pop  = rd_ev & ~buf_empty;
    buf_push = wr_ev & ~buf_full;
    bad      = (rd_ev & buf_empty) | (wr_ev & buf_full);
    wcap_en  = wr_s & ack_s;

    active_n = active_q;
    dir_n    = dir_q;
    sel_n    = sel_q;
    done_n   = done_q;
    err_n    = err_q;
    cnt_n    = cnt_q;
    if (arm) begin
      active_n = 1'b1;
      dir_n    = dir_t'(dir_in);
      sel_n    = ep_sel;
      done_n   = 1'b0;
      err_n    = 1'b0;
      cnt_n    = '0;
    end else begin
      if (eot_rise && active_q) begin
        active_n = 1'b0;
        done_n   = 1'b1;
      end
      if (bad) err_n = 1'b1;
      if (buf_pop || buf_push) cnt_n = cnt_q + 1'b1;
    end
    dreq_n = active_n & ~ack_only &
             ((dir_n == DIR_IN) ? ~buf_full : ~buf_empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      dir_q    <= DIR_OUT;
      sel_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      cnt_q    <= '0;
      dreq_q   <= 1'b0;
    end else begin
      active_q <= active_n;
      dir_q    <= dir_n;
      sel_q    <= sel_n;
      done_q   <= done_n;
      err_q    <= err_n;
      cnt_q    <= cnt_n;
      dreq_q   <= dreq_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wcap_q <= '0;
    else if (wcap_en) wcap_q <= bus_wdata;
  end

  assign bus_oe    = ack_s & rd_s & go & (dir_q == DIR_OUT);
  assign dreq      = dreq_q;
  assign buf_sel   = sel_q;
  assign buf_wdata = wcap_q;
  assign xfer_done = done_q;
  assign xfer_err  = err_q;
  assign word_cnt  = cnt_q;
endmodule

// File: rtl/flyby_dma_port.sv
module flyby_dma_port
  import fbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_only,
  input  logic              dir_in,
  input  logic [EP_W-1:0]   ep_sel,
  input  logic              arm,
  input  logic              dma_ack,
  input  logic              rd_strb,
  input  logic              wr_strb,
  input  logic              eot,
  output logic              dreq,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_oe,
  output logic [EP_W-1:0]   buf_sel,
  input  logic [WORD_W-1:0] buf_rdata,
  input  logic              buf_empty,
  input  logic              buf_full,
  output logic              buf_pop,
  output logic              buf_push,
  output logic [WORD_W-1:0] buf_wdata,
  output logic              xfer_done,
  output logic              xfer_err,
  output logic [CNT_W-1:0]  word_cnt
);
  localparam int unsigned NSYNC = 4;
  localparam int unsigned NEDGE = 3;

  logic             rst_m_q, rst_s_q;
  logic [NSYNC-1:0] raw, syn;
  logic [NEDGE-1:0] rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  assign raw = {eot, wr_strb, rd_strb, dma_ack};

  fbd_sync #(.N(NSYNC)) u_sync (
    .clk(clk), .rst_n(rst_s_q), .d(raw), .q(syn)
  );

  fbd_edge #(.N(NEDGE)) u_edge (
    .clk(clk), .rst_n(rst_s_q), .lvl(syn[NSYNC-1:1]), .rise(rise), .fall(fall)
  );

  fbd_ctrl #(.DW(WORD_W), .EW(EP_W), .CW(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_s_q),
    .ack_only(ack_only), .dir_in(dir_in), .ep_sel(ep_sel), .arm(arm),
    .ack_s(syn[0]), .rd_s(syn[1]), .wr_s(syn[2]),
    .rd_fall(fall[0]), .wr_fall(fall[1]), .eot_rise(rise[2]),
    .bus_wdata(bus_wdata), .buf_empty(buf_empty), .buf_full(buf_full),
    .dreq(dreq), .bus_oe(bus_oe), .buf_sel(buf_sel),
    .buf_pop(buf_pop), .buf_push(buf_push), .buf_wdata(buf_wdata),
    .xfer_done(xfer_done), .xfer_err(xfer_err), .word_cnt(word_cnt)
  );

  assign bus_rdata = buf_rdata;
endmodule

// File: rtl/fbd_checker.sv
module fbd_checker
  import fbd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ack_only,
  input logic             arm,
  input logic             dreq,
  input logic             buf_pop,
  input logic             buf_push,
  input logic             buf_empty,
  input logic             buf_full,
  input logic             xfer_done,
  input logic [CNT_W-1:0] word_cnt
);
  p_one_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_pop && buf_push));

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_pop |-> !buf_empty);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_push |-> !buf_full);

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((buf_pop || buf_push) && !arm) |=> (word_cnt == $past(word_cnt) + 1'b1));

  p_ackonly_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_only |=> !dreq);

  p_done_drops_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_done) |-> !dreq);

  p_arm_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (word_cnt == '0 && !xfer_done));
endmodule

bind flyby_dma_port fbd_checker u_fbd_checker (
  .clk(clk), .rst_n(rst_n), .ack_only(ack_only), .arm(arm), .dreq(dreq),
  .buf_pop(buf_pop), .buf_push(buf_push), .buf_empty(buf_empty),
  .buf_full(buf_full), .xfer_done(xfer_done), .word_cnt(word_cnt)
);

// File: tb/test_flyby_dma_port.sv
`timescale 1ns/1ps
module test_flyby_dma_port;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ack_only, dir_in, arm, dma_ack, rd_strb, wr_strb, eot;
  logic [3:0]  ep_sel;
  logic [15:0] bus_wdata, bus_rdata, buf_wdata, buf_rdata;
  logic        dreq, bus_oe, buf_empty, buf_full, buf_pop, buf_push;
  logic        xfer_done, xfer_err;
  logic [3:0]  buf_sel;
  logic [15:0] word_cnt;

  int errors = 0;
  int checks = 0;
  logic [15:0] mem [DEPTH];
  int rp = 0, wp = 0, lvl = 0;

  always #5 clk = ~clk;

  flyby_dma_port i_flyby_dma_port (.*);

  assign buf_empty = (lvl == 0);
  assign buf_full  = (lvl == DEPTH);
  assign buf_rdata = mem[rp];

  always @(posedge clk) begin
    if (buf_pop && lvl > 0) begin
      rp  <= (rp + 1) % DEPTH;
      lvl <= lvl - 1;
    end
    if (buf_push && lvl < DEPTH) begin
      mem[wp] <= buf_wdata;
      wp  <= (wp + 1) % DEPTH;
      lvl <= lvl + 1;
    end
  end

  function automatic logic [15:0] exp_word(input int seed, input int k);
    return 16'(seed * 40503 + k * 977 + 16'h1234);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fill(input int seed, input int n);
    @(negedge clk);
    for (int k = 0; k < n; k++) mem[k] = exp_word(seed, k);
    rp = 0; wp = n % DEPTH; lvl = n;
  endtask

  task automatic do_arm(input logic d, input logic [3:0] ep);
    @(negedge clk);
    dir_in = d; ep_sel = ep; arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    cyc(2);
  endtask

  task automatic rd_word(input logic ack, output logic [15:0] seen, output logic oe);
    dma_ack = ack; cyc(3);
    rd_strb = 1'b1; cyc(3 + $urandom_range(0, 3));
    seen = bus_rdata; oe = bus_oe;
    rd_strb = 1'b0; cyc(4);
    dma_ack = 1'b0; cyc(1);
  endtask

  task automatic wr_word(input logic ack, input logic [15:0] w);
    dma_ack = ack; bus_wdata = w; cyc(3);
    wr_strb = 1'b1; cyc(3 + $urandom_range(0, 3));
    wr_strb = 1'b0; cyc(4);
    dma_ack = 1'b0; cyc(1);
  endtask

  initial begin
    logic [15:0] seen;
    logic        oe;
    logic [15:0] wv [DEPTH];
    void'($urandom(32'd77));
    rst_n = 1'b0; ack_only = 0; dir_in = 0; arm = 0; dma_ack = 0;
    rd_strb = 0; wr_strb = 0; eot = 0; ep_sel = 4'd0; bus_wdata = '0;
    cyc(4);
    chk("R1 dreq", dreq, 0); chk("R1 oe", bus_oe, 0);
    chk("R1 cnt", word_cnt, 0);
    rst_n = 1'b1; cyc(4);
    chk("R1 done", xfer_done, 0); chk("R1 err", xfer_err, 0);
    chk("R1 dreq after", dreq, 0);

    // OUT transfer: drain random-length buffer, then one extra strobe
    for (int pass = 0; pass < 3; pass++) begin
      int n = 1 + $urandom_range(0, DEPTH - 1);
      fill(pass, n);
      do_arm(1'b0, 4'b1101 + 4'(pass % 3));
      chk("R10 sel", buf_sel, 4'b1101 + pass % 3);
      chk("R2 dreq armed out", dreq, 1);
      ep_sel = 4'b0000; dir_in = 1'b1;
      for (int k = 0; k < n; k++) begin
        rd_word(1'b1, seen, oe);
        chk("R3 oe", oe, 1);
        chk("R3 data", seen, exp_word(pass, k));
        chk("R4 cnt", word_cnt, k + 1);
      end
      chk("R10 latched", buf_sel, 4'b1101 + pass % 3);
      chk("R2 dreq empty", dreq, 0);
      chk("R7 err clear", xfer_err, 0);
      rd_word(1'b1, seen, oe);
      chk("R7 err set", xfer_err, 1);
      chk("R7 cnt hold", word_cnt, n);
    end

    // R6: strobe without acknowledge
    fill(9, 3);
    do_arm(1'b0, 4'b1110);
    chk("R10 clear err", xfer_err, 0);
    chk("R10 clear cnt", word_cnt, 0);
    rd_word(1'b0, seen, oe);
    chk("R6 oe", oe, 0);
    chk("R6 cnt", word_cnt, 0);
    chk("R6 lvl", lvl, 3);

    // R8: end of transfer
    rd_word(1'b1, seen, oe);
    chk("R4 one pop", lvl, 2);
    eot = 1'b1; cyc(5); eot = 1'b0; cyc(2);
    chk("R8 done", xfer_done, 1);
    chk("R8 dreq", dreq, 0);
    rd_word(1'b1, seen, oe);
    chk("R8 no move", lvl, 2);
    chk("R8 cnt", word_cnt, 1);
    do_arm(1'b0, 4'b1110);
    chk("R10 done clr", xfer_done, 0);

    // R9: ack-only mode
    ack_only = 1'b1; cyc(3);
    chk("R9 dreq", dreq, 0);
    rd_word(1'b1, seen, oe);
    chk("R9 lvl", lvl, 2);
    chk("R9 oe", oe, 0);
    ack_only = 1'b0;

    // IN transfer: fill to full with random words, one extra strobe
    fill(0, 0);
    do_arm(1'b1, 4'b1111);
    chk("R2 dreq armed in", dreq, 1);
    for (int k = 0; k < DEPTH; k++) begin
      wv[k] = 16'($urandom);
      wr_word(1'b1, wv[k]);
      chk("R5 lvl", lvl, k + 1);
    end
    for (int k = 0; k < DEPTH; k++) chk("R5 data", mem[k], wv[k]);
    chk("R2 dreq full", dreq, 0);
    wr_word(1'b1, 16'hDEAD);
    chk("R7 full err", xfer_err, 1);
    chk("R7 full cnt", word_cnt, DEPTH);
    chk("R7 full mem", mem[0], wv[0]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule